// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset-Cause Record

This block is a watchdog timer on a simple single-cycle register bus. The bus has an address, a write enable, write data and combinational read data. Software chooses an enable and a power-of-two timeout in a configuration word. It keeps the system alive by writing two fixed key words, in a fixed order, to two refresh locations.

If the count runs out while the watchdog is armed, the block raises a system reset request. It does the same when software writes a wrong key or writes the keys out of order. A dedicated write location lets software request a reset directly. Every request holds the reset line high for a fixed number of cycles. The block records why the last reset happened in a small code that its own requests do not clear.

Configuration writes are only staged. The running watchdog picks up the staged enable and timeout only when a refresh completes. This applies to turning the watchdog off as well, so a stray write alone cannot disarm it.

Top module: `mkWatchdog`

## Requirements
- R1: While `hardRstN` is low at a rising edge, the block resets: `rstReq` is low afterwards, the cause code reads 0, the configuration reads 0, and the watchdog is not counting.
- R2: Only word-aligned addresses with all higher bits zero are decoded. Word 1 (byte address 0x04) holds the staged configuration: bit 31 is enable and bits [4:0] are the delay code. It reads back with all other bits zero. A write there does not change the running watchdog.
- R3: A refresh is valid when 0xABCD1234 is written to word 2 (0x08) and the very next bus write puts 0x4321DCBA into word 3 (0x0C). At the edge of that second write, the staged configuration becomes active and the counter reloads.
- R4: With the active enable set and delay code d, `rstReq` rises at the 2^(d+1)-th rising edge after the edge that completed the last valid refresh.
- R5: The following writes are bad refreshes: any value other than 0xABCD1234 written to word 2, or any write to word 3 that does not complete a valid refresh. While the active enable is set, a bad refresh raises `rstReq` at its own edge and sets the cause to 2. While the active enable is clear, a bad refresh has no effect.
- R6: A write to word 0 (0x00) with data bit 0 set raises `rstReq` at its edge and sets the cause to 3, whether or not the watchdog is enabled. A write there with bit 0 clear has no effect.
- R7: Every reset request holds `rstReq` high for exactly PULSE_LEN cycles and ignores bus writes during that time. Afterwards the watchdog is disabled with delay code 0, and the configuration reads 0.
- R8: Word 2 reads the cause code in bits [2:0], with all other bits zero. The codes are 0 for hard reset, 1 for timeout, 2 for bad refresh, 3 for software request and 4 for external reset. The cause survives the block's own reset requests.
- R9: A high `extRst` at a rising edge sets the cause to 4 and leaves the watchdog disabled with configuration 0. It does not raise `rstReq`.
- R10: Clearing the enable in the configuration does not stop a running count. The count stops only when a valid refresh completes after the clearing write.
- R11: Word 0 and word 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| hardRstN | input | 1 | Synchronous power-on reset, active low; clears everything including the cause |
| extRst | input | 1 | Synchronous external reset, active high; recorded as cause 4 |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWe | input | 1 | Write strobe, one write per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| rstReq | output | 1 | System reset request |

## Verification
The bench keeps the default address width and delay-code width, so the full 5-bit code and the 32-bit counter are built. It only uses delay codes 0, 1 and 3 for expiry, which gives periods of 2, 4 and 16 cycles. Code 31 is checked only as a count that does not expire within a short window. PULSE_LEN is set to 4, which keeps each reset pulse short. This lets the bench reach many request, recovery and cause-overwrite sequences in a few hundred cycles.

// File: rtl/mkWdgPkg.sv
package mkWdgPkg;

  localparam logic [31:0] KEY_FIRST  = 32'hABCD1234;
  localparam logic [31:0] KEY_SECOND = 32'h4321DCBA;

  // word indices of the register map
  localparam int WORD_SOFT = 0;
  localparam int WORD_CFG  = 1;
  localparam int WORD_KEY1 = 2;
  localparam int WORD_KEY2 = 3;

  typedef enum logic [2:0] {
    CAUSE_HARD    = 3'd0,
    CAUSE_TIMEOUT = 3'd1,
    CAUSE_BADKEY  = 3'd2,
    CAUSE_SOFT    = 3'd3,
    CAUSE_EXT     = 3'd4
  } cause_e;

  // one-cycle strobes from bus decode into the datapath
  typedef struct packed {
    logic cfgWr;
    logic softHit;
    logic badKey;
    logic goodKey;
    logic rdCfg;
    logic rdCause;
  } strobes_t;

endpackage

// File: rtl/mkWdgCtrl.sv
module mkWdgCtrl
  import mkWdgPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              extRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  input  logic              blocked,
  output strobes_t          strb
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr;
  logic              hitSoft, hitCfg, hitKey1, hitKey2;
  logic              firstOk;
  logic              armed;

  assign word    = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign hitSoft = aligned && (word == WORD_W'(WORD_SOFT));
  assign hitCfg  = aligned && (word == WORD_W'(WORD_CFG));
  assign hitKey1 = aligned && (word == WORD_W'(WORD_KEY1));
  assign hitKey2 = aligned && (word == WORD_W'(WORD_KEY2));

  assign wr      = busWe && !blocked;
  assign firstOk = wr && hitKey1 && (busWdata == KEY_FIRST);

  always_comb begin
    strb         = '0;
    strb.cfgWr   = wr && hitCfg;
    strb.softHit = wr && hitSoft && busWdata[0];
    strb.goodKey = wr && hitKey2 && armed && (busWdata == KEY_SECOND);
    strb.badKey  = wr && ((hitKey1 && (busWdata != KEY_FIRST)) ||
                          (hitKey2 && !(armed && (busWdata == KEY_SECOND))));
    strb.rdCfg   = hitCfg;
    strb.rdCause = hitKey1;
  end

  // the first key arms only the very next write
  always_ff @(posedge clk) begin
    if (!hardRstN || extRst || blocked) armed <= 1'b0;
    else if (busWe)                     armed <= firstOk;
  end

  assert_one_strobe_R5 : assert property (@(posedge clk) disable iff (!hardRstN)
    $onehot0({strb.cfgWr, strb.softHit, strb.badKey, strb.goodKey}));

  assert_first_arms_R3 : assert property (@(posedge clk) disable iff (!hardRstN)
    (busWe && !blocked && !extRst && hitKey1 && busWdata == KEY_FIRST) |=> armed);

endmodule

// File: rtl/mkWdgDatapath.sv
module mkWdgDatapath
  import mkWdgPkg::*;
#(
  parameter int DELAY_W   = 5,
  parameter int PULSE_LEN = 16
) (
  input  logic               clk,
  input  logic               hardRstN,
  input  logic               extRst,
  input  strobes_t           strb,
  input  logic               wrEnable,
  input  logic [DELAY_W-1:0] wrDelay,
  output logic               rstReq,
  output logic [31:0]        busRdata
);

  localparam int CNT_W = 2 ** DELAY_W;
  localparam int PC_W  = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [DELAY_W-1:0] MAX_DLY = '1;

  logic               pendEn, actEn;
  logic [DELAY_W-1:0] pendDly, actDly;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   reloadVal;
  logic [PC_W-1:0]    pulseCnt;
  cause_e             cause;

  logic   fireTimeout, fire;
  cause_e fireCode;

  // 2^(d+1)-1 without needing a wider intermediate
  assign reloadVal = {CNT_W{1'b1}} >> (MAX_DLY - pendDly);

  assign fireTimeout = actEn && (cnt == '0) && !strb.goodKey;

  always_comb begin
    fire     = 1'b1;
    fireCode = CAUSE_TIMEOUT;
    if (strb.softHit)               fireCode = CAUSE_SOFT;
    else if (strb.badKey && actEn)  fireCode = CAUSE_BADKEY;
    else if (fireTimeout)           fireCode = CAUSE_TIMEOUT;
    else                            fire     = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!hardRstN || extRst) begin
      pendEn   <= 1'b0;
      pendDly  <= '0;
      actEn    <= 1'b0;
      actDly   <= '0;
      cnt      <= '0;
      rstReq   <= 1'b0;
      pulseCnt <= '0;
      cause    <= hardRstN ? CAUSE_EXT : CAUSE_HARD;
    end else if (rstReq) begin
      if (pulseCnt == '0) rstReq <= 1'b0;
      else                pulseCnt <= pulseCnt - PC_W'(1);
    end else if (fire) begin
      rstReq   <= 1'b1;
      pulseCnt <= PC_W'(PULSE_LEN - 1);
      cause    <= fireCode;
      pendEn   <= 1'b0;
      pendDly  <= '0;
      actEn    <= 1'b0;
      actDly   <= '0;
      cnt      <= '0;
    end else begin
      if (strb.cfgWr) begin
        pendEn  <= wrEnable;
        pendDly <= wrDelay;
      end
      if (strb.goodKey) begin
        actEn  <= pendEn;
        actDly <= pendDly;
        cnt    <= reloadVal;
      end else if (actEn) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdCfg) begin
      busRdata[31]          = pendEn;
      busRdata[DELAY_W-1:0] = pendDly;
    end else if (strb.rdCause) begin
      busRdata[2:0] = cause;
    end
  end

  assert_count_down_R4 : assert property (@(posedge clk) disable iff (!hardRstN)
    (actEn && !rstReq && !extRst && cnt != '0 && !strb.goodKey && !strb.softHit && !strb.badKey)
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_bad_key_R5 : assert property (@(posedge clk) disable iff (!hardRstN)
    (strb.badKey && actEn && !rstReq && !extRst) |=> (rstReq && cause == CAUSE_BADKEY));

  assert_soft_req_R6 : assert property (@(posedge clk) disable iff (!hardRstN)
    (strb.softHit && !rstReq && !extRst) |=> (rstReq && cause == CAUSE_SOFT));

  assert_cleared_after_R7 : assert property (@(posedge clk) disable iff (!hardRstN)
    $fell(rstReq) |-> (!actEn && !pendEn && pendDly == '0 && actDly == '0));

  assert_cause_kept_R8 : assert property (@(posedge clk) disable iff (!hardRstN)
    (rstReq && !extRst) |=> (cause == $past(cause)));

endmodule

// File: rtl/mkWatchdog.sv
module mkWatchdog
  import mkWdgPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DELAY_W   = 5,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              extRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              rstReq
);

  strobes_t strb;

  mkWdgCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .hardRstN (hardRstN),
    .extRst   (extRst),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .blocked  (rstReq),
    .strb     (strb)
  );

  mkWdgDatapath #(.DELAY_W(DELAY_W), .PULSE_LEN(PULSE_LEN)) i_dp (
    .clk      (clk),
    .hardRstN (hardRstN),
    .extRst   (extRst),
    .strb     (strb),
    .wrEnable (busWdata[31]),
    .wrDelay  (busWdata[DELAY_W-1:0]),
    .rstReq   (rstReq),
    .busRdata (busRdata)
  );

endmodule

// File: tb/test_mkWatchdog.sv
module test_mkWatchdog;

  localparam int PULSE = 4;
  localparam logic [31:0] K1 = 32'hABCD1234;
  localparam logic [31:0] K2 = 32'h4321DCBA;

  logic        clk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        extRst = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rstReq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  mkWatchdog #(.ADDR_W(4), .DELAY_W(5), .PULSE_LEN(PULSE)) i_mkWatchdog (
    .clk(clk), .hardRstN(hardRstN), .extRst(extRst), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic refresh();
    busWrite(4'h8, K1);
    busWrite(4'hC, K2);
  endtask

  task automatic expectReq(input logic exp, input string tag);
    check(rstReq === exp, tag, {31'b0, rstReq}, {31'b0, exp});
  endtask

  task automatic expectReg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v === exp, tag, v, exp);
  endtask

  task automatic testReset();
    expectReq(1'b0, "R1 req low after hard reset");
    expectReg(4'h8, 32'd0, "R1 cause zero after hard reset");
    expectReg(4'h4, 32'd0, "R1 config zero after hard reset");
    tick(50);
    expectReq(1'b0, "R1 idle watchdog does not fire");
    expectReg(4'h0, 32'd0, "R11 word0 reads zero");
    expectReg(4'hC, 32'd0, "R11 word3 reads zero");
  endtask

  task automatic testStaged();
    busWrite(4'h4, 32'h8000_0000);
    expectReg(4'h4, 32'h8000_0000, "R2 staged config reads back");
    tick(20);
    expectReq(1'b0, "R2 staged config not active");
    busWrite(4'h4, 32'hFFFF_FFFF);
    expectReg(4'h4, 32'h8000_001F, "R2 only enable and delay stored");
    refresh();
    tick(60);
    expectReq(1'b0, "R2 code 31 does not expire early");
    busWrite(4'h4, 32'h0);
    refresh();
    busWrite(4'h8, 32'h0);
    expectReq(1'b0, "R5 bad key ignored when disabled");
    expectReg(4'h8, 32'd0, "R5 cause unchanged when disabled");
  endtask

  task automatic timeoutRun(input int d);
    int n;
    n = 1 << (d + 1);
    busWrite(4'h4, 32'h8000_0000 | d);
    refresh();
    tick(n - 1);
    expectReq(1'b0, $sformatf("R4 no fire before edge %0d (d=%0d)", n, d));
    tick(1);
    expectReq(1'b1, $sformatf("R4 fire at edge %0d (d=%0d)", n, d));
    expectReg(4'h8, 32'd1, "R8 timeout cause");
    tick(PULSE - 1);
    expectReq(1'b1, "R7 pulse still high");
    tick(1);
    expectReq(1'b0, "R7 pulse ended after PULSE_LEN");
    expectReg(4'h4, 32'd0, "R7 config cleared after request");
    expectReg(4'h8, 32'd1, "R8 cause survives own request");
  endtask

  task automatic testKeepAlive();
    busWrite(4'h4, 32'h8000_0002);
    refresh();
    for (int i = 0; i < 6; i++) begin
      tick(3);
      refresh();
      expectReq(1'b0, "R3 regular refresh keeps alive");
    end
    busWrite(4'hC, K2);
    expectReq(1'b1, "R5 second key without first");
    expectReg(4'h8, 32'd2, "R5 cause bad key");
    tick(PULSE + 2);
  endtask

  task automatic testBadOrders();
    busWrite(4'h4, 32'h8000_0003);
    refresh();
    busWrite(4'h8, 32'h1234_5678);
    expectReq(1'b1, "R5 wrong first key");
    tick(PULSE + 2);
    busWrite(4'h4, 32'h8000_0003);
    refresh();
    busWrite(4'h8, K1);
    busWrite(4'h4, 32'h8000_0003);
    expectReq(1'b0, "R2 config write is not a bad key");
    busWrite(4'hC, K2);
    expectReq(1'b1, "R3 intervening write breaks sequence");
    tick(PULSE + 2);
    busWrite(4'h4, 32'h8000_0003);
    refresh();
    busWrite(4'h8, K1);
    busWrite(4'hC, 32'h0);
    expectReq(1'b1, "R5 wrong second key");
    expectReg(4'h8, 32'd2, "R5 cause after wrong second key");
    tick(PULSE + 2);
  endtask

  task automatic testDisable();
    busWrite(4'h4, 32'h8000_0001);
    refresh();
    busWrite(4'h4, 32'h0);
    expectReg(4'h4, 32'h0, "R10 staged disable visible");
    tick(2);
    expectReq(1'b0, "R10 not yet expired");
    tick(1);
    expectReq(1'b1, "R10 clearing enable alone does not stop count");
    tick(PULSE + 2);
    busWrite(4'h4, 32'h8000_0001);
    refresh();
    busWrite(4'h4, 32'h0);
    refresh();
    tick(40);
    expectReq(1'b0, "R10 disable takes effect on refresh");
    expectReg(4'h8, 32'd1, "R8 cause still timeout");
  endtask

  task automatic testSoft();
    busWrite(4'h0, 32'h0000_0002);
    expectReq(1'b0, "R6 bit0 clear has no effect");
    busWrite(4'h0, 32'h1);
    expectReq(1'b1, "R6 soft request while disabled");
    expectReg(4'h8, 32'd3, "R6 soft cause");
    busWrite(4'h4, 32'h8000_0005);
    tick(PULSE + 2);
    expectReg(4'h4, 32'd0, "R7 write during pulse ignored");
  endtask

  task automatic testExternal();
    busWrite(4'h4, 32'h8000_0001);
    refresh();
    extRst = 1'b1;
    @(negedge clk);
    extRst = 1'b0;
    expectReq(1'b0, "R9 external reset raises no request");
    expectReg(4'h8, 32'd4, "R9 external cause");
    expectReg(4'h4, 32'd0, "R9 config cleared");
    tick(20);
    expectReq(1'b0, "R9 watchdog disabled after external reset");
    hardRstN = 1'b0;
    @(negedge clk);
    hardRstN = 1'b1;
    expectReg(4'h8, 32'd0, "R8 hard reset clears cause");
    expectReg(4'h9, 32'd0, "R2 unaligned address not decoded");
  endtask

  initial begin
    tick(3);
    hardRstN = 1'b1;
    testReset();
    testStaged();
    timeoutRun(0);
    timeoutRun(1);
    timeoutRun(3);
    testKeepAlive();
    testBadOrders();
    testDisable();
    testSoft();
    testExternal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule